// File: doc/BRIEF.md
# Masked Bit-Field Store Unit

This block writes a bit field of any position and width into one 32-bit word of memory while leaving every other bit of that word as it was. A request supplies a base byte pointer, a position operand, a width and a data operand. A mask/value generator turns these into a 32-bit mask and a matching aligned value. An address stage forms the word-aligned address of the target.

A sequencer then reads the target word over a valid/ready memory port and merges the field into it under the mask. It writes the merged word back to the same address. The port stays locked for the whole exchange, so no other access can fall between the read and the write. The main use is updating single fields of memory-mapped peripheral registers.

Two request forms exist. In field mode the caller gives the position and the width directly. In bit mode a single bit is stored at a bit-granular address: the bit offset selects both the word and the bit within it, and the stored bit is taken from bit 0 of the data operand.

Top module: `bitfield_store`

## Requirements
- R1: The mask holds `width` consecutive ones starting at the selected position; mask bits that would lie above bit 31 are dropped (position 28, width 8 gives mask 32'hF000_0000).
- R2: The field value is the data operand shifted left by the position and cut to the mask; data 4'b1011 at position 7 with width 4 gives mask 32'h0000_0780 and value 32'h0000_0580.
- R3: The word written back equals (old & ~mask) | (value & mask), where old is the word returned by the read.
- R4: The access address has its two low bits forced to zero. In field mode (bit_mode = 0) it is base_ptr aligned. In bit mode (bit_mode = 1) it is base_ptr + (op_pos >> 3), aligned afterwards.
- R5: In bit mode the width is 1, the position is op_pos[4:0], and the stored bit is op_data[0]; op_width is ignored.
- R6: Only op_pos[4:0] selects the bit position in both modes; higher bits of op_pos do not move the field.
- R7: Each accepted request produces exactly one read (mem_req_we = 0) followed by exactly one write (mem_req_we = 1) to the same address. A request is held stable with mem_req_valid high until mem_req_ready is seen.
- R8: mem_lock is high from the cycle after start is accepted until the write handshake completes, and covers every request. A start pulse while mem_lock is high is ignored.
- R9: done is high for exactly one cycle, in the cycle after the write handshake, and mem_lock is low in that cycle.
- R10: A width of 0 in field mode gives an empty mask, so the written word equals the word read.
- R11: While and after synchronous reset, mem_req_valid, mem_lock and done are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a store; sampled only when idle |
| bit_mode | input | 1 | 1: single-bit store at a bit-granular address; 0: field store |
| base_ptr | input | 32 | Byte pointer to the target |
| op_pos | input | 32 | Position (field mode) or bit offset (bit mode) |
| op_width | input | 5 | Field width in field mode |
| op_data | input | 32 | Data operand; bit 0 alone is used in bit mode |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 for write, 0 for read |
| mem_req_addr | output | 32 | Word-aligned request address |
| mem_req_wdata | output | 32 | Merged word for the write |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| mem_lock | output | 1 | Port held for the read-modify-write |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume the memory side behaves properly. It returns exactly one response for each accepted read, never before the read handshake, and never while a write is pending. The bench memory model follows this rule: it answers each read two cycles after the handshake and accepts requests either at once or on a repeating stall pattern. Bit-mode stimulus uses word-aligned base pointers, so the offset's low five bits name the bit within the addressed word. Start pulses sent during a busy exchange test that the request is dropped, and the word that request named is checked to be unchanged.

// File: rtl/bfs_pkg.sv
package bfs_pkg;

    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 32;
    localparam int POS_W   = $clog2(DATA_W);
    localparam int BYTE_SH = 3;
    localparam int ALIGN_W = $clog2(DATA_W / 8);

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        word_t mask;
        word_t value;
    } field_t;

    typedef struct packed {
        addr_t  addr;
        field_t fld;
    } job_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_RD_REQ,
        S_RD_WAIT,
        S_WR_REQ
    } seq_state_t;

    function automatic word_t merge_word(input word_t old_w, input field_t f);
        return (old_w & ~f.mask) | (f.value & f.mask);
    endfunction

endpackage

// File: rtl/bfs_mask_gen.sv
module bfs_mask_gen
    import bfs_pkg::*;
(
    input  logic [POS_W-1:0] pos,
    input  logic [POS_W-1:0] width,
    input  word_t            data,
    output field_t           fld
);

    logic [POS_W:0] lo_edge;
    logic [POS_W:0] hi_edge;
    word_t          mask_w;
    word_t          shifted;

    assign lo_edge = {1'b0, pos};
    assign hi_edge = {1'b0, pos} + {1'b0, width};

    // Each bit decides on its own whether it lies in [pos, pos+width);
    // bits past the top of the word simply do not exist.
    genvar gi;
    generate
        for (gi = 0; gi < DATA_W; gi++) begin : g_bit
            localparam logic [POS_W:0] IDX = (POS_W+1)'(gi);
            assign mask_w[gi] = (IDX >= lo_edge) && (IDX < hi_edge);
        end
    endgenerate

    assign shifted = data << pos;

    always_comb begin
        fld.mask  = mask_w;
        fld.value = shifted & mask_w;
    end

endmodule

// File: rtl/bfs_addr_scale.sv
module bfs_addr_scale
    import bfs_pkg::*;
(
    input  addr_t base,
    input  word_t bit_off,
    input  logic  bit_mode,
    output addr_t word_addr
);

    addr_t byte_addr;

    always_comb begin
        if (bit_mode)
            byte_addr = base + addr_t'(bit_off >> BYTE_SH);
        else
            byte_addr = base;
        word_addr = {byte_addr[ADDR_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
    end

endmodule

// File: rtl/bfs_rmw_seq.sv
module bfs_rmw_seq
    import bfs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  job_t  job,
    output logic  mem_req_valid,
    input  logic  mem_req_ready,
    output logic  mem_req_we,
    output addr_t mem_req_addr,
    output word_t mem_req_wdata,
    input  logic  mem_rsp_valid,
    input  word_t mem_rsp_data,
    output logic  mem_lock,
    output logic  done
);

    seq_state_t state_q;
    job_t       job_q;
    word_t      wdata_q;
    logic       done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            job_q   <= '0;
            wdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                S_IDLE: begin
                    if (start) begin
                        job_q   <= job;
                        state_q <= S_RD_REQ;
                    end
                end
                S_RD_REQ: begin
                    if (mem_req_ready)
                        state_q <= S_RD_WAIT;
                end
                S_RD_WAIT: begin
                    if (mem_rsp_valid) begin
                        wdata_q <= merge_word(mem_rsp_data, job_q.fld);
                        state_q <= S_WR_REQ;
                    end
                end
                S_WR_REQ: begin
                    if (mem_req_ready) begin
                        state_q <= S_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req_valid = (state_q == S_RD_REQ) || (state_q == S_WR_REQ);
        mem_req_we    = (state_q == S_WR_REQ);
        mem_req_addr  = job_q.addr;
        mem_req_wdata = wdata_q;
        mem_lock      = (state_q != S_IDLE);
        done          = done_q;
    end

    // R7: a stalled request keeps its address and direction
    a_r7_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)));

    // R8: every request is issued under the lock
    a_r8_lock_cover: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> mem_lock);

    // R9: completion follows an accepted write and leaves the port free
    a_r9_done_after_write: assert property (@(posedge clk) disable iff (rst)
        done |-> (!mem_lock && $past(mem_req_valid && mem_req_we && mem_req_ready)));

    // R9: the completion pulse lasts one cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R3: bits outside the mask are carried over from the read word
    a_r3_unmasked_kept: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_RD_WAIT && mem_rsp_valid) |=>
            ((mem_req_wdata & ~job_q.fld.mask) == ($past(mem_rsp_data) & ~job_q.fld.mask)));

    // R4: every access is word aligned
    a_r4_aligned: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> (mem_req_addr[ALIGN_W-1:0] == '0));

    // R11: nothing pending right after reset
    a_r11_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (!mem_req_valid && !mem_lock && !done));

endmodule

// File: rtl/bitfield_store.sv
module bitfield_store
    import bfs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              bit_mode,
    input  logic [ADDR_W-1:0] base_ptr,
    input  logic [DATA_W-1:0] op_pos,
    input  logic [POS_W-1:0]  op_width,
    input  logic [DATA_W-1:0] op_data,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_we,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              mem_lock,
    output logic              done
);

    logic [POS_W-1:0] sel_pos;
    logic [POS_W-1:0] sel_width;
    field_t           fld;
    addr_t            word_addr;
    job_t             job;

    // Position always comes from the low bits of the operand; bit mode
    // forces a one-bit field.
    assign sel_pos   = op_pos[POS_W-1:0];
    assign sel_width = bit_mode ? POS_W'(1) : op_width;

    bfs_mask_gen u_mask (
        .pos   (sel_pos),
        .width (sel_width),
        .data  (op_data),
        .fld   (fld)
    );

    bfs_addr_scale u_addr (
        .base      (base_ptr),
        .bit_off   (op_pos),
        .bit_mode  (bit_mode),
        .word_addr (word_addr)
    );

    always_comb begin
        job.addr = word_addr;
        job.fld  = fld;
    end

    bfs_rmw_seq u_seq (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .job           (job),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_we    (mem_req_we),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .mem_lock      (mem_lock),
        .done          (done)
    );

endmodule

// File: tb/bitfield_store_test.sv
`timescale 1ns/1ps
module bitfield_store_test;

    typedef struct packed {
        logic        bm;
        logic [31:0] base;
        logic [31:0] pos;
        logic [4:0]  w;
        logic [31:0] data;
        logic [31:0] old;
        logic [31:0] eaddr;
        logic [31:0] eword;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        // R2 example field into zero word
        '{1'b0, 32'h10, 32'd7,  5'd4,  32'h0000_000B, 32'h0000_0000, 32'h10, 32'h0000_0580},
        // R3 same field into all-ones word
        '{1'b0, 32'h10, 32'd7,  5'd4,  32'h0000_000B, 32'hFFFF_FFFF, 32'h10, 32'hFFFF_FDFF},
        // R4 unaligned base pointer in field mode
        '{1'b0, 32'h13, 32'd4,  5'd2,  32'h0000_0003, 32'h0000_0000, 32'h10, 32'h0000_0030},
        // R1 field running past bit 31
        '{1'b0, 32'h20, 32'd28, 5'd8,  32'h0000_00FF, 32'h0000_0000, 32'h20, 32'hF000_0000},
        // R6 high position bits ignored (0x45 -> 5)
        '{1'b0, 32'h20, 32'h45, 5'd3,  32'h0000_0007, 32'h0000_0000, 32'h20, 32'h0000_00E0},
        // R2 data bits beyond the width cut off
        '{1'b0, 32'h24, 32'd8,  5'd4,  32'hFFFF_FFF5, 32'h1234_5678, 32'h24, 32'h1234_5578},
        // R5 bit mode set: offset 43 -> addr 0x04, bit 11
        '{1'b1, 32'h00, 32'd43, 5'd9,  32'h0000_0001, 32'h0000_0000, 32'h04, 32'h0000_0800},
        // R5 bit mode clear: offset 63 -> addr 0x0C, bit 31
        '{1'b1, 32'h08, 32'd63, 5'd9,  32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'h0C, 32'h7FFF_FFFF},
        // R10 width zero leaves word unchanged
        '{1'b0, 32'h30, 32'd3,  5'd0,  32'h0000_00FF, 32'hA5A5_A5A5, 32'h30, 32'hA5A5_A5A5},
        // R1 width 31 from bit 0
        '{1'b0, 32'h34, 32'd0,  5'd31, 32'h0000_0000, 32'hFFFF_FFFF, 32'h34, 32'h8000_0000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        bit_mode = 1'b0;
    logic [31:0] base_ptr = '0;
    logic [31:0] op_pos = '0;
    logic [4:0]  op_width = '0;
    logic [31:0] op_data = '0;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic        mem_req_we;
    logic [31:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        mem_lock;
    logic        done;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    bitfield_store uut (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .bit_mode      (bit_mode),
        .base_ptr      (base_ptr),
        .op_pos        (op_pos),
        .op_width      (op_width),
        .op_data       (op_data),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_we    (mem_req_we),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .mem_lock      (mem_lock),
        .done          (done)
    );

    // ---------------- memory model ----------------
    logic [31:0] mem [16];
    logic        slow = 1'b0;
    logic [1:0]  stall_cnt;
    logic        pre_en = 1'b0;
    logic [3:0]  pre_idx = '0;
    logic [31:0] pre_data = '0;
    logic        rsp_pend;
    logic [3:0]  rsp_idx;
    logic        rsp_v;
    logic [31:0] rsp_d;
    int          rd_cnt;
    int          wr_cnt;
    logic [31:0] last_raddr;
    logic [31:0] last_waddr;

    assign mem_req_ready = slow ? (stall_cnt == 2'b11) : 1'b1;
    assign mem_rsp_valid = rsp_v;
    assign mem_rsp_data  = rsp_d;

    always @(posedge clk) begin
        if (rst) begin
            stall_cnt  <= '0;
            rsp_pend   <= 1'b0;
            rsp_idx    <= '0;
            rsp_v      <= 1'b0;
            rsp_d      <= '0;
            rd_cnt     <= 0;
            wr_cnt     <= 0;
            last_raddr <= '0;
            last_waddr <= '0;
        end else begin
            stall_cnt <= stall_cnt + 2'd1;
            rsp_v     <= 1'b0;
            if (pre_en) mem[pre_idx] <= pre_data;
            if (rsp_pend) begin
                rsp_v    <= 1'b1;
                rsp_d    <= mem[rsp_idx];
                rsp_pend <= 1'b0;
            end
            if (mem_req_valid && mem_req_ready) begin
                if (mem_req_we) begin
                    mem[mem_req_addr[5:2]] <= mem_req_wdata;
                    wr_cnt     <= wr_cnt + 1;
                    last_waddr <= mem_req_addr;
                end else begin
                    rd_cnt     <= rd_cnt + 1;
                    rsp_pend   <= 1'b1;
                    rsp_idx    <= mem_req_addr[5:2];
                    last_raddr <= mem_req_addr;
                end
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic preload(input logic [31:0] addr, input logic [31:0] val);
        @(negedge clk);
        pre_en   = 1'b1;
        pre_idx  = addr[5:2];
        pre_data = val;
        @(negedge clk);
        pre_en   = 1'b0;
    endtask

    task automatic drive(input vec_t v);
        bit_mode = v.bm;
        base_ptr = v.base;
        op_pos   = v.pos;
        op_width = v.w;
        op_data  = v.data;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!done && n < 200) begin
            @(negedge clk);
            n++;
        end
        chk(done, req, 32'(done), 32'd1);
    endtask

    task automatic run_vec(input vec_t v, input int k);
        int rc;
        int wc;
        preload(v.eaddr, v.old);
        rc = rd_cnt;
        wc = wr_cnt;
        drive(v);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(mem_lock, "R8 lock after start", 32'(mem_lock), 32'd1);
        wait_done("R9 done seen");
        chk(mem[v.eaddr[5:2]] == v.eword, $sformatf("R3 word vec%0d", k),
            mem[v.eaddr[5:2]], v.eword);
        chk(last_waddr == v.eaddr, $sformatf("R4 write addr vec%0d", k), last_waddr, v.eaddr);
        chk(last_raddr == v.eaddr, $sformatf("R7 read addr vec%0d", k), last_raddr, v.eaddr);
        chk(rd_cnt == rc + 1 && wr_cnt == wc + 1, $sformatf("R7 one read one write vec%0d", k),
            32'(wr_cnt - wc), 32'd1);
        @(negedge clk);
        chk(!done && !mem_lock, "R9 single pulse, idle", {30'd0, done, mem_lock}, 32'd0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R7 watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // ---------------- main ----------------
    initial begin
        vec_t v;
        int   wc;
        repeat (3) @(negedge clk);
        chk(!mem_req_valid && !mem_lock && !done, "R11 in reset",
            {29'd0, mem_req_valid, mem_lock, done}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(!mem_req_valid && !mem_lock && !done, "R11 after reset",
            {29'd0, mem_req_valid, mem_lock, done}, 32'd0);

        for (int k = 0; k < NVEC; k++) begin
            slow = (k % 2) == 1;
            run_vec(VECS[k], k);
        end

        // R5 op_width ignored in bit mode: width 31 given, one bit changes
        slow = 1'b0;
        v = '{1'b1, 32'h18, 32'd2, 5'd31, 32'hFFFF_FFFF, 32'h0000_0000, 32'h18, 32'h0000_0004};
        run_vec(v, 20);

        // R8 start while locked is ignored
        slow = 1'b1;
        preload(32'h38, 32'h0000_0000);
        v = VECS[0];
        preload(v.eaddr, 32'h0000_0000);
        wc = wr_cnt;
        drive(v);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        bit_mode = 1'b0;
        base_ptr = 32'h38;
        op_pos   = 32'd0;
        op_width = 5'd8;
        op_data  = 32'hFF;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done("R8 done during ignore test");
        chk(mem[14] == 32'h0, "R8 ignored start left word", mem[14], 32'h0);
        chk(mem[4] == 32'h580, "R8 first request intact", mem[4], 32'h580);
        repeat (12) @(negedge clk);
        chk(wr_cnt == wc + 1 && !mem_lock, "R8 no extra write", 32'(wr_cnt - wc), 32'd1);

        // R11 reset mid-operation clears the lock
        drive(VECS[2]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        rst   = 1'b1;
        @(negedge clk);
        chk(!mem_req_valid && !mem_lock && !done, "R11 reset mid-op",
            {29'd0, mem_req_valid, mem_lock, done}, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule